// File: doc/BRIEF.md
# 10 Mb/s Transmit Jabber Guard

This block sits on the transmit side of a media-independent interface running at 10 Mb/s. It stops one station from holding the shared medium with a transmission that never ends. A prescaler divides the system clock into coarse ticks, nominally one millisecond each. A transmit timer counts those ticks for as long as the transmit enable stays high. If the enable is still high when the timer reaches its limit, the guard enters a jam state. In that state it forces the forwarded enable low and the forwarded data to zero, and it sets a sticky status flag.

The jam state does not end when the enable simply drops. The enable must stay low for an unbroken unjam interval, nominally 500 ticks. Any high cycle during that interval starts the count again from zero. The transmit limit, the unjam interval and the tick length are all parameters, so a bench can run with short values. When the 10 Mb/s mode input is low, the transmit timer is held at zero and the guard never trips.

Top module: `jabg_guard`

## Requirements
- R1: While reset is held and just after it, `jam_active` and `jam_sticky` are 0 and the gated outputs equal `mii_tx_en` and `mii_txd`.
- R2: Outside the jam state, `tx_en_gated` equals `mii_tx_en` and `txd_gated` equals `mii_txd`, with no delay.
- R3: With `ten_mode`=1, a burst in which `mii_tx_en` is high for at most (TX_LIMIT-1)*CLKS_PER_TICK consecutive clocks never causes the jam state.
- R4: With `ten_mode`=1, a burst in which `mii_tx_en` is high for TX_LIMIT*CLKS_PER_TICK consecutive clocks has set `jam_active` by the end of that burst.
- R5: The transmit timer is cleared whenever `mii_tx_en` is low. Short bursts separated by a single low clock therefore never add up to a trip.
- R6: While `jam_active`=1, `tx_en_gated` is 0 and `txd_gated` is all zeros, whatever the inputs are.
- R7: `jam_sticky` becomes 1 on entry to the jam state. It stays 1 until a clock with `stat_rd`=1, which clears it even if the jam state continues. Entry in the same clock as a read leaves it set.
- R8: The jam state ends after `mii_tx_en` has been low for UNJAM_TICKS*CLKS_PER_TICK+1 consecutive clocks. It is still active after (UNJAM_TICKS-1)*CLKS_PER_TICK low clocks.
- R9: A single clock with `mii_tx_en`=1 during the unjam interval restarts it, so the time already spent low does not count.
- R10: With `ten_mode`=0, the transmit timer does not run and no burst length causes the jam state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ten_mode | input | 1 | 1 when the port runs at 10 Mb/s; enables the guard timer |
| mii_tx_en | input | 1 | Transmit enable from the MAC |
| mii_txd | input | DATA_W | Transmit data nibble from the MAC |
| stat_rd | input | 1 | Status read strobe; clears the sticky flag |
| tx_en_gated | output | 1 | Transmit enable forwarded to the line side |
| txd_gated | output | DATA_W | Transmit data forwarded to the line side |
| jam_active | output | 1 | 1 while the jam state holds |
| jam_sticky | output | 1 | Latched jam event flag, cleared by a read |

## Verification
The bench targets the tick-phase margins on both timers. It uses one burst just under the limit and one at the limit, and one idle period just under the unjam interval and one just over it. A design that counts clocks instead of ticks, or is off by one tick, would trip early or release late there. A lone high clock inside the unjam interval catches a design that only waits for the enable to fall, which would release the jam too soon. Back-to-back short bursts catch a timer that is not cleared between frames, which would trip on legal traffic. A status read during an ongoing jam catches a sticky flag that is wired to the live state.

// File: rtl/jabg_pkg.sv
package jabg_pkg;

  typedef enum logic {
    GS_OPEN = 1'b0,
    GS_JAM  = 1'b1
  } guard_state_t;

  // Width able to hold values 0..max_val
  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

  // True when a counter sits on the final step of a span of 'span' steps
  function automatic logic at_final(input int unsigned cnt, input int unsigned span);
    return (cnt == span - 1);
  endfunction

endpackage

// File: rtl/jabg_prescale.sv
module jabg_prescale #(
  parameter int unsigned CLKS_PER_TICK = 25000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  import jabg_pkg::*;

  localparam int unsigned PW = cnt_width(CLKS_PER_TICK - 1);

  logic [PW-1:0] div_cnt;
  logic          wrap_now;

  assign wrap_now = at_final(int'(div_cnt), CLKS_PER_TICK);
  assign tick     = wrap_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_cnt <= '0;
    else if (wrap_now) div_cnt <= '0;
    else               div_cnt <= div_cnt + 1'b1;
  end

  // Ticks never come on adjacent clocks when the divider is above one (R3, R4)
  if (CLKS_PER_TICK > 1) begin : g_gap_chk
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
  end

endmodule

// File: rtl/jabg_tx_timer.sv
module jabg_tx_timer #(
  parameter int unsigned TX_LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tx_en,
  input  logic ten_mode,
  input  logic jam,
  output logic expire
);
  import jabg_pkg::*;

  localparam int unsigned TW = cnt_width(TX_LIMIT);

  logic [TW-1:0] tx_cnt;
  logic          run;
  logic          last_step;

  assign run       = tx_en & ten_mode & ~jam;
  assign last_step = at_final(int'(tx_cnt), TX_LIMIT);
  assign expire    = run & tick & last_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            tx_cnt <= '0;
    else if (!run)         tx_cnt <= '0;
    else if (tick) begin
      if (last_step)       tx_cnt <= '0;
      else                 tx_cnt <= tx_cnt + 1'b1;
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt < TW'(TX_LIMIT));

  p_expire_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> ten_mode);

  // After a clock with the enable low the count restarts from zero (R5)
  p_low_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (tx_cnt == '0));

endmodule

// File: rtl/jabg_unjam.sv
module jabg_unjam #(
  parameter int unsigned UNJAM_TICKS = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tx_en,
  input  logic enter,
  output logic jam,
  output logic leave
);
  import jabg_pkg::*;

  localparam int unsigned IW = cnt_width(UNJAM_TICKS);

  guard_state_t  state;
  logic [IW-1:0] idle_cnt;
  logic          idle_last;

  assign jam       = (state == GS_JAM);
  assign idle_last = at_final(int'(idle_cnt), UNJAM_TICKS);
  assign leave     = jam & ~tx_en & tick & idle_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state <= GS_OPEN;
    else if (enter) state <= GS_JAM;
    else if (leave) state <= GS_OPEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              idle_cnt <= '0;
    else if (!jam || tx_en)  idle_cnt <= '0;
    else if (tick) begin
      if (idle_last)         idle_cnt <= '0;
      else                   idle_cnt <= idle_cnt + 1'b1;
    end
  end

  p_jam_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (jam && !leave) |=> jam);

  p_leave_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    leave |-> !tx_en);

  p_enter_leave_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(enter && leave));

endmodule

// File: rtl/jabg_guard.sv
module jabg_guard #(
  parameter int unsigned CLKS_PER_TICK = 25000,
  parameter int unsigned TX_LIMIT      = 100,
  parameter int unsigned UNJAM_TICKS   = 500,
  parameter int unsigned DATA_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ten_mode,
  input  logic              mii_tx_en,
  input  logic [DATA_W-1:0] mii_txd,
  input  logic              stat_rd,
  output logic              tx_en_gated,
  output logic [DATA_W-1:0] txd_gated,
  output logic              jam_active,
  output logic              jam_sticky
);

  logic tick_w;
  logic expire_w;
  logic leave_w;
  logic jam_w;

  jabg_prescale #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_w)
  );

  jabg_tx_timer #(.TX_LIMIT(TX_LIMIT)) u_txt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_w),
    .tx_en    (mii_tx_en),
    .ten_mode (ten_mode),
    .jam      (jam_w),
    .expire   (expire_w)
  );

  jabg_unjam #(.UNJAM_TICKS(UNJAM_TICKS)) u_unj (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_w),
    .tx_en (mii_tx_en),
    .enter (expire_w),
    .jam   (jam_w),
    .leave (leave_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        jam_sticky <= 1'b0;
    else if (expire_w) jam_sticky <= 1'b1;
    else if (stat_rd)  jam_sticky <= 1'b0;
  end

  assign jam_active  = jam_w;
  assign tx_en_gated = mii_tx_en & ~jam_w;
  assign txd_gated   = jam_w ? '0 : mii_txd;

  p_entry_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w |=> jam_active);

  p_sticky_on_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jam_active) |-> jam_sticky);

  p_release_after_leave_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jam_active) |-> $past(leave_w));

endmodule

// File: tb/jabg_guard_tb.sv
module jabg_guard_tb_top;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned P  = 4;
  localparam int unsigned L  = 5;
  localparam int unsigned U  = 6;
  localparam int unsigned DW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ten_mode;
  logic          mii_tx_en;
  logic [DW-1:0] mii_txd;
  logic          stat_rd;
  logic          tx_en_gated;
  logic [DW-1:0] txd_gated;
  logic          jam_active;
  logic          jam_sticky;

  int unsigned n_total = 0;
  int unsigned n_bad   = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jabg_guard #(.CLKS_PER_TICK(P), .TX_LIMIT(L), .UNJAM_TICKS(U), .DATA_W(DW)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ten_mode    (ten_mode),
    .mii_tx_en   (mii_tx_en),
    .mii_txd     (mii_txd),
    .stat_rd     (stat_rd),
    .tx_en_gated (tx_en_gated),
    .txd_gated   (txd_gated),
    .jam_active  (jam_active),
    .jam_sticky  (jam_sticky)
  );

  typedef struct packed {
    int unsigned burst;
    int unsigned idle;
    logic        ten;
    logic        jam_after_burst;
    logic        jam_after_idle;
  } vec_t;

  // Trip bound L*P=20, safe bound (L-1)*P=16, release bound U*P+1=25
  localparam vec_t VECS [8] = '{
    '{16,  4, 1'b1, 1'b0, 1'b0},
    '{21, 26, 1'b1, 1'b1, 1'b0},
    '{40, 26, 1'b1, 1'b1, 1'b0},
    '{40,  4, 1'b0, 1'b0, 1'b0},
    '{ 8,  1, 1'b1, 1'b0, 1'b0},
    '{12,  8, 1'b1, 1'b0, 1'b0},
    '{24, 30, 1'b1, 1'b1, 1'b0},
    '{200, 4, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle_clks(input int unsigned n);
    mii_tx_en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_clks(input int unsigned n, input logic [DW-1:0] d);
    mii_tx_en = 1'b1;
    mii_txd   = d;
    repeat (n) @(negedge clk);
  endtask

  task automatic read_status();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  initial begin
    rst_n     = 1'b0;
    ten_mode  = 1'b1;
    mii_tx_en = 1'b1;
    mii_txd   = 4'h3;
    stat_rd   = 1'b0;
    repeat (3) @(negedge clk);
    // R1: during reset the gate passes and nothing is flagged
    chk("R1 jam in reset", 32'(jam_active), 32'd0);
    chk("R1 sticky in reset", 32'(jam_sticky), 32'd0);
    chk("R1 en passes in reset", 32'(tx_en_gated), 32'd1);
    mii_tx_en = 1'b0;
    rst_n     = 1'b1;
    @(negedge clk);
    chk("R1 jam after reset", 32'(jam_active), 32'd0);

    // Table walk
    for (int i = 0; i < 8; i++) begin
      vec_t v;
      string rq;
      logic [DW-1:0] d;
      v  = VECS[i];
      d  = DW'(i + 5);
      ten_mode = v.ten;
      rq = !v.ten ? "R10" : (v.jam_after_burst ? "R4" : "R3");
      send_clks(v.burst, d);
      chk(rq, 32'(jam_active), 32'(v.jam_after_burst));
      chk(v.jam_after_burst ? "R6 en" : "R2 en", 32'(tx_en_gated), 32'(!v.jam_after_burst));
      chk(v.jam_after_burst ? "R6 data" : "R2 data", 32'(txd_gated),
          v.jam_after_burst ? 32'd0 : 32'(d));
      idle_clks(v.idle);
      chk("R8 table idle", 32'(jam_active), 32'(v.jam_after_idle));
      chk("R7 table sticky", 32'(jam_sticky), 32'(v.jam_after_burst));
      read_status();
      chk("R7 table read", 32'(jam_sticky), 32'd0);
    end
    ten_mode = 1'b1;

    // R5: five bursts at the safe bound with one low clock between
    for (int k = 0; k < 5; k++) begin
      send_clks(16, 4'hC);
      idle_clks(1);
    end
    chk("R5 no accumulation", 32'(jam_active), 32'd0);

    // R6: trip, then vary data while the enable stays high
    send_clks(24, 4'h1);
    chk("R4 directed trip", 32'(jam_active), 32'd1);
    for (int k = 0; k < 3; k++) begin
      mii_txd = DW'(4'hF - k);
      @(negedge clk);
      chk("R6 data zero", 32'(txd_gated), 32'd0);
      chk("R6 en low", 32'(tx_en_gated), 32'd0);
    end

    // R7: read during an ongoing jam clears only the flag
    read_status();
    chk("R7 read clears", 32'(jam_sticky), 32'd0);
    chk("R7 jam persists", 32'(jam_active), 32'd1);

    // R9: one high clock inside the unjam interval restarts it
    idle_clks(20);
    chk("R8 short idle", 32'(jam_active), 32'd1);
    send_clks(1, 4'h7);
    chk("R6 en low in unjam", 32'(tx_en_gated), 32'd0);
    idle_clks(20);
    chk("R9 restart", 32'(jam_active), 32'd1);
    idle_clks(6);
    chk("R8 release", 32'(jam_active), 32'd0);
    chk("R7 no re-set", 32'(jam_sticky), 32'd0);

    // R2: pass-through after release
    send_clks(3, 4'h9);
    chk("R2 en after release", 32'(tx_en_gated), 32'd1);
    chk("R2 data after release", 32'(txd_gated), 32'h9);
    idle_clks(2);
    chk("R2 en low follows", 32'(tx_en_gated), 32'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_total++;
      n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

endmodule